// File: doc/BRIEF.md
# Longest Identical-Run Position Tracker

This block sits behind the iterative key-equation stage of a burst-error Reed-Solomon decoder. Each outer iteration of that stage produces one candidate error-locator polynomial together with its paired error-evaluator polynomial. The tracker watches this stream and looks for the longest unbroken run of iterations whose locator polynomials are identical. At the end it reports the locator and evaluator pair that belongs to the final member of that run.

A run is extended when the arriving locator matches the locator of the run in progress on every coefficient. Any difference, even in one coefficient, closes the run and opens a new one of length one. The best pair is replaced only when the current run grows strictly longer than the best run so far. A tie therefore keeps the earlier run. While the best run keeps growing, its recorded pair follows its newest member. The upstream stage marks the final iteration with a last flag. One cycle later the tracker raises a single-cycle done pulse, and the result outputs hold until the next start.

Top module: `burst_run_tracker`

## Requirements
- R1: After reset, and in the cycle after `start` is sampled high, `best_loc`, `best_evl` and `best_len` are zero and `done` is low.
- R2: The first candidate accepted after reset or start opens a run of length 1 and becomes the best pair, with `best_len` = 1.
- R3: A candidate extends the current run by one when its locator equals the run's locator in every coefficient. The evaluator is never compared, and a difference confined to the highest coefficient still counts as a mismatch.
- R4: A candidate whose locator differs from the run's locator opens a new run of length 1.
- R5: The best pair is replaced only when the current run length becomes strictly greater than `best_len`. On a tie the earlier run is kept.
- R6: The recorded `best_loc`/`best_evl` pair is the one carried by the last candidate of the longest run.
- R7: `done` is high for exactly one cycle. It rises in the cycle after the candidate carrying `cand_last` is accepted, and the result outputs are final in that same cycle.
- R8: After `done`, further candidates are ignored: the outputs keep their values and `done` stays low until `start`.
- R9: `start` clears all tracking state, including in the middle of a sequence. A candidate presented in the same cycle as `start` is ignored.
- R10: Run length saturates at 2^LEN_W-1 (31 by default). A saturated best run still hands its newest member's pair to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new codeword; clears all tracking state |
| cand_valid | input | 1 | A candidate pair is present this cycle |
| cand_last | input | 1 | Present candidate is from the final outer iteration |
| cand_loc | input | SYM_W*LOC_N | Candidate locator, coefficient k in bits [k*SYM_W +: SYM_W] |
| cand_evl | input | SYM_W*EVL_N | Candidate evaluator, same packing |
| best_loc | output | SYM_W*LOC_N | Locator of the last member of the longest run |
| best_evl | output | SYM_W*EVL_N | Evaluator paired with best_loc |
| best_len | output | LEN_W | Length of the longest run |
| done | output | 1 | One-cycle pulse: result is final |

## Verification
Every result register is loaded on the same edge that accepts a candidate. The final outputs and `done` are therefore due one edge after the edge that takes the candidate flagged last. The bench drives on falling edges and reads `done` and the three result outputs on the next falling edge. It then confirms on the falling edge after that that `done` has dropped. For the ignore and hold cases, it drives candidates after `done` and compares the outputs on every following falling edge against the values captured at `done`.

// File: rtl/burst_run_pkg.sv
package burst_run_pkg;

    localparam int unsigned DEF_SYM_W = 8;
    localparam int unsigned DEF_LOC_N = 5;
    localparam int unsigned DEF_EVL_N = 4;
    localparam int unsigned DEF_LEN_W = 5;

    typedef enum logic [1:0] {
        TRK_WAIT_FIRST = 2'd0,
        TRK_RUN        = 2'd1,
        TRK_FINISHED   = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic load_first;
        logic shift;
        logic equal;
        logic take_best;
    } trk_ctrl_t;

endpackage

// File: rtl/burst_run_cmp.sv
module burst_run_cmp #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned NCOEF = 5
) (
    input  logic [SYM_W*NCOEF-1:0] poly_a,
    input  logic [SYM_W*NCOEF-1:0] poly_b,
    output logic                   same
);
    logic [NCOEF-1:0] coef_eq;

    for (genvar k = 0; k < NCOEF; k++) begin : g_coef
        assign coef_eq[k] = (poly_a[k*SYM_W +: SYM_W] == poly_b[k*SYM_W +: SYM_W]);
    end

    assign same = &coef_eq;
endmodule

// File: rtl/burst_run_sched.sv
module burst_run_sched
    import burst_run_pkg::*;
#(
    parameter int unsigned LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cand_valid,
    input  logic             cand_last,
    input  logic             loc_same,
    output trk_ctrl_t        ctrl,
    output logic [LEN_W-1:0] best_len,
    output logic             done
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    trk_state_e       state;
    logic [LEN_W-1:0] run_len;
    logic [LEN_W-1:0] next_len;
    logic             cur_is_best;
    logic             accept;

    always_comb begin
        accept          = cand_valid && !start && (state != TRK_FINISHED);
        ctrl.load_first = accept && (state == TRK_WAIT_FIRST);
        ctrl.shift      = accept && (state == TRK_RUN);
        ctrl.equal      = ctrl.shift && loc_same;
        if (ctrl.equal)
            next_len = (run_len == LEN_MAX) ? run_len : run_len + LEN_ONE;
        else
            next_len = LEN_ONE;
        ctrl.take_best  = ctrl.load_first ||
                          (ctrl.equal && (cur_is_best || (next_len > best_len)));
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state       <= TRK_WAIT_FIRST;
            run_len     <= '0;
            best_len    <= '0;
            cur_is_best <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= accept && cand_last;
            if (ctrl.load_first || ctrl.shift) begin
                run_len     <= next_len;
                cur_is_best <= ctrl.take_best;
                if (ctrl.take_best)
                    best_len <= next_len;
                state <= cand_last ? TRK_FINISHED : TRK_RUN;
            end
        end
    end

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    mismatch_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.shift && !ctrl.equal && !start) |=> (run_len == LEN_ONE));

    // R5
    best_covers_run_chk: assert property (@(posedge clk) disable iff (rst)
        best_len >= run_len);

    // R8
    finished_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TRK_FINISHED && !start) |=> ($stable(best_len) && !done));

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (best_len == '0 && !done && run_len == '0));
endmodule

// File: rtl/burst_run_regs.sv
module burst_run_regs
    import burst_run_pkg::*;
#(
    parameter int unsigned LOC_W = 40,
    parameter int unsigned EVL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  trk_ctrl_t        ctrl,
    input  logic [LOC_W-1:0] cand_loc,
    input  logic [EVL_W-1:0] cand_evl,
    output logic [LOC_W-1:0] run_loc,
    output logic [LOC_W-1:0] best_loc,
    output logic [EVL_W-1:0] best_evl
);
    always_ff @(posedge clk) begin
        if (rst || start) begin
            run_loc  <= '0;
            best_loc <= '0;
            best_evl <= '0;
        end else begin
            if (ctrl.load_first || (ctrl.shift && !ctrl.equal))
                run_loc <= cand_loc;
            if (ctrl.take_best) begin
                best_loc <= cand_loc;
                best_evl <= cand_evl;
            end
        end
    end

    // R3
    equal_means_match_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.equal |-> (cand_loc == run_loc));

    // R9
    start_clears_pair_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (best_loc == '0 && best_evl == '0));
endmodule

// File: rtl/burst_run_tracker.sv
module burst_run_tracker
    import burst_run_pkg::*;
#(
    parameter int unsigned SYM_W = DEF_SYM_W,
    parameter int unsigned LOC_N = DEF_LOC_N,
    parameter int unsigned EVL_N = DEF_EVL_N,
    parameter int unsigned LEN_W = DEF_LEN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   cand_valid,
    input  logic                   cand_last,
    input  logic [SYM_W*LOC_N-1:0] cand_loc,
    input  logic [SYM_W*EVL_N-1:0] cand_evl,
    output logic [SYM_W*LOC_N-1:0] best_loc,
    output logic [SYM_W*EVL_N-1:0] best_evl,
    output logic [LEN_W-1:0]       best_len,
    output logic                   done
);
    localparam int unsigned LOC_W = SYM_W * LOC_N;
    localparam int unsigned EVL_W = SYM_W * EVL_N;

    trk_ctrl_t        ctrl;
    logic             loc_same;
    logic [LOC_W-1:0] run_loc;

    burst_run_cmp #(.SYM_W(SYM_W), .NCOEF(LOC_N)) u_cmp (
        .poly_a (cand_loc),
        .poly_b (run_loc),
        .same   (loc_same)
    );

    burst_run_sched #(.LEN_W(LEN_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cand_valid (cand_valid),
        .cand_last  (cand_last),
        .loc_same   (loc_same),
        .ctrl       (ctrl),
        .best_len   (best_len),
        .done       (done)
    );

    burst_run_regs #(.LOC_W(LOC_W), .EVL_W(EVL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ctrl     (ctrl),
        .cand_loc (cand_loc),
        .cand_evl (cand_evl),
        .run_loc  (run_loc),
        .best_loc (best_loc),
        .best_evl (best_evl)
    );
endmodule

// File: tb/test_burst_run_tracker.sv
module test_burst_run_tracker;
    localparam int LW = 40;
    localparam int EW = 32;
    localparam int LEN_W = 5;
    localparam int LEN_MAX = (1 << LEN_W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cand_valid = 1'b0;
    logic          cand_last = 1'b0;
    logic [LW-1:0] cand_loc = '0;
    logic [EW-1:0] cand_evl = '0;
    logic [LW-1:0] best_loc;
    logic [EW-1:0] best_evl;
    logic [LEN_W-1:0] best_len;
    logic          done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [LW-1:0] seq_loc [64];
    logic [EW-1:0] seq_evl [64];
    logic [LW-1:0] exp_loc;
    logic [EW-1:0] exp_evl;
    int            exp_len;
    logic [LW-1:0] pool [3];

    always #4 clk = ~clk;

    burst_run_tracker i_burst_run_tracker (
        .clk(clk), .rst(rst), .start(start), .cand_valid(cand_valid),
        .cand_last(cand_last), .cand_loc(cand_loc), .cand_evl(cand_evl),
        .best_loc(best_loc), .best_evl(best_evl), .best_len(best_len), .done(done)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model(int n);
        int run = 0;
        int best = 0;
        bit cur = 0;
        for (int i = 0; i < n; i++) begin
            int nl;
            bit eq;
            bit take;
            eq = (i > 0) && (seq_loc[i] == seq_loc[i-1]);
            nl = eq ? ((run < LEN_MAX) ? run + 1 : run) : 1;
            take = (i == 0) || (eq && (cur || nl > best));
            if (take) begin
                best = nl;
                exp_loc = seq_loc[i];
                exp_evl = seq_evl[i];
            end
            cur = take;
            run = nl;
        end
        exp_len = best;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        cand_valid = 1'b0;
        cand_last = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drive(logic [LW-1:0] l, logic [EW-1:0] e, logic last);
        @(negedge clk);
        start = 1'b0;
        cand_valid = 1'b1;
        cand_loc = l;
        cand_evl = e;
        cand_last = last;
    endtask

    task automatic run_seq(string req, int n);
        pulse_start();
        for (int i = 0; i < n; i++)
            drive(seq_loc[i], seq_evl[i], i == n - 1);
        @(negedge clk);
        cand_valid = 1'b0;
        cand_last = 1'b0;
        model(n);
        chk({req, " done"}, 64'(done), 64'd1);
        chk({req, " loc"}, 64'(best_loc), 64'(exp_loc));
        chk({req, " evl"}, 64'(best_evl), 64'(exp_evl));
        chk({req, " len"}, 64'(best_len), 64'(exp_len));
        @(negedge clk);
        chk("R7 done falls", 64'(done), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset loc", 64'(best_loc), 64'd0);
        chk("R1 reset evl", 64'(best_evl), 64'd0);
        chk("R1 reset len", 64'(best_len), 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);

        // R2 single candidate
        seq_loc[0] = 40'h0102030405; seq_evl[0] = 32'hA1A2A3A4;
        run_seq("R2 single", 1);

        // R5 tie keeps earlier run; R6 last member of it
        seq_loc[0] = 40'h11; seq_evl[0] = 32'h1;
        seq_loc[1] = 40'h11; seq_evl[1] = 32'h2;
        seq_loc[2] = 40'h22; seq_evl[2] = 32'h3;
        seq_loc[3] = 40'h22; seq_evl[3] = 32'h4;
        run_seq("R5 tie", 4);
        chk("R6 tie pair", 64'(best_evl), 64'h2);

        // R4 mismatch then longer run; R6 last member
        seq_loc[0] = 40'h33; seq_evl[0] = 32'h10;
        seq_loc[1] = 40'h44; seq_evl[1] = 32'h11;
        seq_loc[2] = 40'h44; seq_evl[2] = 32'h12;
        seq_loc[3] = 40'h44; seq_evl[3] = 32'h13;
        seq_loc[4] = 40'h55; seq_evl[4] = 32'h14;
        run_seq("R4 restart", 5);
        chk("R6 longest pair", 64'(best_evl), 64'h13);

        // R3 evaluator differs but run extends; top coefficient differs breaks run
        seq_loc[0] = 40'h00AABBCCDD; seq_evl[0] = 32'h5;
        seq_loc[1] = 40'h00AABBCCDD; seq_evl[1] = 32'h6;
        seq_loc[2] = 40'h01AABBCCDD; seq_evl[2] = 32'h7;
        seq_loc[3] = 40'h01AABBCCDD; seq_evl[3] = 32'h8;
        seq_loc[4] = 40'h01AABBCCDD; seq_evl[4] = 32'h9;
        run_seq("R3 coefwise", 5);
        chk("R3 len3 top coef", 64'(best_len), 64'd3);

        // R8 candidates after done are ignored
        for (int i = 0; i < 3; i++) begin
            drive(40'hFFFF0000 + 40'(i), 32'hDEAD0000 + 32'(i), 1'b0);
            @(negedge clk);
            chk("R8 hold loc", 64'(best_loc), 64'(exp_loc));
            chk("R8 hold len", 64'(best_len), 64'(exp_len));
            chk("R8 no done", 64'(done), 64'd0);
        end
        cand_valid = 1'b0;

        // R9 start mid-sequence
        pulse_start();
        drive(40'h77, 32'h70, 1'b0);
        drive(40'h77, 32'h71, 1'b0);
        drive(40'h77, 32'h72, 1'b0);
        @(negedge clk);
        start = 1'b1; cand_valid = 1'b1; cand_loc = 40'h99; cand_evl = 32'h90; cand_last = 1'b1;
        @(negedge clk);
        start = 1'b0; cand_valid = 1'b0; cand_last = 1'b0;
        chk("R9 start ignores cand done", 64'(done), 64'd0);
        chk("R9 start clears len", 64'(best_len), 64'd0);
        drive(40'h88, 32'h80, 1'b1);
        @(negedge clk);
        cand_valid = 1'b0; cand_last = 1'b0;
        chk("R9 fresh done", 64'(done), 64'd1);
        chk("R9 fresh loc", 64'(best_loc), 64'h88);
        chk("R9 fresh len", 64'(best_len), 64'd1);

        // R10 saturation
        for (int i = 0; i < 36; i++) begin
            seq_loc[i] = 40'h5A5A;
            seq_evl[i] = 32'(i + 100);
        end
        run_seq("R10 sat", 36);
        chk("R10 sat len", 64'(best_len), 64'(LEN_MAX));
        chk("R10 sat pair", 64'(best_evl), 64'd135);

        // random sequences R3 R4 R5 R6
        for (int s = 0; s < 25; s++) begin
            int n;
            for (int p = 0; p < 3; p++)
                pool[p] = {8'($urandom), $urandom};
            n = 1 + int'($urandom % 14);
            for (int i = 0; i < n; i++) begin
                seq_loc[i] = pool[$urandom % 3];
                seq_evl[i] = $urandom;
            end
            run_seq("R6 random", n);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule